// File: doc/BRIEF.md
# Byte Lane Parity Generator and Checker

This block sits beside a 32-bit data bus and handles even parity one byte lane at a time. During a write it computes one parity bit per byte of the outgoing data. It drives those bits, with their output enable, over the same clocks as the write data. During a read it recomputes parity over the returned data and compares it with the parity bits that came back with that data. It then reports a mismatch on an active-low status output.

Only lanes that actually carried data take part in the check. A lane counts when its byte enable is asserted and the effective bus width reaches it. The status output is meaningful for exactly one clock, the one right after ready is sampled on a read, and it rests high otherwise. Read data passes through to the core unchanged, whatever the parity result.

Top module: `bpar_gen_check`

## Requirements
- R1: Parity is even and per lane: parity bit i equals the XOR of data bits 8i+7 down to 8i, so each lane plus its parity bit holds an even number of ones.
- R2: The parity output enable is high only in the second and later clocks of a write cycle (`bus_active`=1, `cyc_first`=0, `wr`=1). It is low in the first clock, during reads, and when the bus is idle.
- R3: On a read, the check covers only lanes whose active-low byte enable is 0 and that lie inside the effective bus width. Width code 2'b00 means 32 bits (lanes 0-3), 2'b01 means 16 bits (lanes 0-1), and 2'b10 or 2'b11 means 8 bits (lane 0). Mismatches on excluded lanes are ignored.
- R4: A read ready is taken when `bus_active`=1, `cyc_first`=0, `wr`=0 and `rdy_n`=0. `par_ok_n` is low in the clock after that sample if any covered lane mismatches, and high otherwise.
- R5: `par_ok_n` is high in every clock that does not directly follow a taken read ready. This includes the clocks after write ready, after ready in a cycle's first clock, after ready on an idle bus, and after reset.
- R6: `rd_data` presents, in the clock after a taken read ready, the exact data sampled with that ready, whether or not parity matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_active | input | 1 | A bus cycle is in progress |
| cyc_first | input | 1 | Current clock is the first clock of the cycle |
| wr | input | 1 | 1 for a write cycle, 0 for a read |
| rdy_n | input | 1 | Active-low ready |
| be_n | input | 4 | Active-low byte enables, bit i for lane i |
| width_sel | input | 2 | Effective bus width code (see R3) |
| d | input | 32 | Data on the bus (write data or returned read data) |
| par_in | input | 4 | Parity returned with read data |
| par_out | output | 4 | Generated parity for write data |
| par_oe | output | 1 | Output enable for the parity lines |
| par_ok_n | output | 1 | Active-low parity error status |
| rd_data | output | 32 | Read data handed to the core |

## Verification
A wrong lane mask shows up as a missing or false low on `par_ok_n` in the single clock after the ready that carried the bad lane. A stuck status register shows up as a low `par_ok_n` that outlasts that clock, or as a low after a write, within one clock. A wrong enable decode shows up combinationally on `par_oe` in the same clock as the bad cycle phase. The bench sweeps every byte-enable pattern, every width code and every per-lane parity corruption, so a wrong lane mask cannot go unnoticed.

// File: rtl/bpar_pkg.sv
package bpar_pkg;
  typedef enum logic [1:0] {
    BW_FULL = 2'b00,
    BW_HALF = 2'b01,
    BW_BYTE = 2'b10
  } bus_width_e;
endpackage

// File: rtl/bpar_lane_xor.sv
module bpar_lane_xor #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0] data,
  output logic [LANES-1:0]        par
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign par[i] = ^data[i*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/bpar_lane_mask.sv
module bpar_lane_mask #(
  parameter int LANES = 4
) (
  input  logic [1:0]       width_sel,
  input  logic [LANES-1:0] be_n,
  output logic [LANES-1:0] mask
);
  import bpar_pkg::*;
  localparam int HALF_LANES = (LANES >= 2) ? LANES / 2 : 1;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic in_width;
    always_comb begin
      unique case (width_sel)
        BW_FULL: in_width = 1'b1;
        BW_HALF: in_width = (i < HALF_LANES);
        default: in_width = (i == 0);
      endcase
    end
    assign mask[i] = in_width & ~be_n[i];
  end
endmodule

// File: rtl/bpar_check_reg.sv
module bpar_check_reg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          mismatch,
  input  logic [DW-1:0] d,
  output logic          ok_n,
  output logic [DW-1:0] data_q
);
  logic          ok_n_nxt;
  logic [DW-1:0] data_nxt;

  always_comb begin
    ok_n_nxt = 1'b1;
    data_nxt = data_q;
    if (take) begin
      ok_n_nxt = ~mismatch;
      data_nxt = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_n   <= 1'b1;
      data_q <= '0;
    end else begin
      ok_n <= ok_n_nxt;
      if (take) data_q <= data_nxt;
    end
  end
endmodule

// File: rtl/bpar_gen_check.sv
module bpar_gen_check #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_active,
  input  logic                    cyc_first,
  input  logic                    wr,
  input  logic                    rdy_n,
  input  logic [LANES-1:0]        be_n,
  input  logic [1:0]              width_sel,
  input  logic [LANES*LANE_W-1:0] d,
  input  logic [LANES-1:0]        par_in,
  output logic [LANES-1:0]        par_out,
  output logic                    par_oe,
  output logic                    par_ok_n,
  output logic [LANES*LANE_W-1:0] rd_data
);
  localparam int DW = LANES * LANE_W;

  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic [LANES-1:0] calc_par;
  logic [LANES-1:0] lane_mask;
  logic             data_phase;
  logic             rd_take;
  logic             mismatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  bpar_lane_xor #(.LANES(LANES), .LANE_W(LANE_W)) u_xor (
    .data (d),
    .par  (calc_par)
  );

  bpar_lane_mask #(.LANES(LANES)) u_mask (
    .width_sel (width_sel),
    .be_n      (be_n),
    .mask      (lane_mask)
  );

  assign data_phase = bus_active & ~cyc_first;
  assign rd_take    = data_phase & ~wr & ~rdy_n;
  assign mismatch   = |(lane_mask & (calc_par ^ par_in));
  assign par_out    = calc_par;
  assign par_oe     = data_phase & wr;

  bpar_check_reg #(.DW(DW)) u_reg (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .take     (rd_take),
    .mismatch (mismatch),
    .d        (d),
    .ok_n     (par_ok_n),
    .data_q   (rd_data)
  );
endmodule

// File: rtl/bpar_gen_check_chk.sv
module bpar_gen_check_chk #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_active,
  input logic                    cyc_first,
  input logic                    wr,
  input logic                    rdy_n,
  input logic [LANES-1:0]        be_n,
  input logic [1:0]              width_sel,
  input logic [LANES*LANE_W-1:0] d,
  input logic [LANES-1:0]        par_in,
  input logic [LANES-1:0]        par_out,
  input logic                    par_oe,
  input logic                    par_ok_n,
  input logic [LANES*LANE_W-1:0] rd_data
);
  logic strobe;
  assign strobe = bus_active & ~cyc_first & ~wr & ~rdy_n;

  a_r1_even_total: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe |-> (($countones({d, par_out}) & 1) == 0));

  a_r2_oe_phase: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe |-> (bus_active && !cyc_first && wr));

  a_r2_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_active |-> !par_oe);

  a_r3_no_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && (&be_n)) |=> par_ok_n);

  a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> par_ok_n);

  a_r6_data_pass: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (rd_data == $past(d)));

  a_r4_match_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && (par_in == par_out)) |=> par_ok_n);
endmodule

bind bpar_gen_check bpar_gen_check_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/sim_bpar_gen_check.sv
module sim_bpar_gen_check;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_active, cyc_first, wr, rdy_n;
  logic [3:0]  be_n;
  logic [1:0]  width_sel;
  logic [31:0] d;
  logic [3:0]  par_in;
  logic [3:0]  par_out;
  logic        par_oe, par_ok_n;
  logic [31:0] rd_data;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  bpar_gen_check u0 (.*);

  function automatic logic [3:0] lane_par(input logic [31:0] v);
    for (int i = 0; i < 4; i++) lane_par[i] = ($countones(v[i*8 +: 8]) % 2) == 1;
  endfunction

  function automatic logic [3:0] width_mask(input logic [1:0] w);
    return (w == 2'b00) ? 4'hF : (w == 2'b01) ? 4'h3 : 4'h1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    bus_active = 0; cyc_first = 0; wr = 0; rdy_n = 1;
    be_n = 4'hF; width_sel = 0; d = 0; par_in = 0;
  endtask

  task automatic read_cycle(input logic [3:0] be, input logic [1:0] w,
                            input logic [3:0] flip, input logic [31:0] v);
    logic exp_ok_n;
    // first clock: ready here must be ignored
    @(negedge clk);
    bus_active = 1; cyc_first = 1; wr = 0; rdy_n = 0;
    be_n = be; width_sel = w; d = ~v; par_in = lane_par(~v) ^ 4'hF;
    @(negedge clk);
    chk(par_ok_n == 1'b1, "R5 first-clock ready ignored", par_ok_n, 1);
    chk(par_oe == 1'b0, "R2 oe low on read", par_oe, 0);
    cyc_first = 0; d = v; par_in = lane_par(v) ^ flip;
    @(negedge clk);
    exp_ok_n = ~|(~be & width_mask(w) & flip);
    chk(par_ok_n == exp_ok_n, "R3 R4 masked status", par_ok_n, exp_ok_n);
    chk(rd_data == v, "R6 data unchanged", rd_data, v);
    idle();
    @(negedge clk);
    chk(par_ok_n == 1'b1, "R5 status one clock only", par_ok_n, 1);
  endtask

  task automatic write_cycle(input logic [31:0] v);
    @(negedge clk);
    bus_active = 1; cyc_first = 1; wr = 1; rdy_n = 1; be_n = 0; d = v; par_in = ~lane_par(v);
    #1 chk(par_oe == 1'b0, "R2 oe low in first clock", par_oe, 0);
    @(negedge clk);
    cyc_first = 0; rdy_n = 0;
    #1 chk(par_oe == 1'b1, "R2 oe high in data clocks", par_oe, 1);
    chk(par_out == lane_par(v), "R1 lane parity", par_out, lane_par(v));
    @(negedge clk);
    chk(par_ok_n == 1'b1, "R5 write ready no status", par_ok_n, 1);
    idle();
    #1 chk(par_oe == 1'b0, "R2 oe low when idle", par_oe, 0);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(par_ok_n == 1'b1, "R5 reset state", par_ok_n, 1);
    chk(par_oe == 1'b0, "R2 reset oe", par_oe, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // ready on an idle bus with bad parity must not report
    rdy_n = 0; par_in = 4'hF;
    @(negedge clk);
    chk(par_ok_n == 1'b1, "R5 idle ready ignored", par_ok_n, 1);
    idle();
    for (int k = 0; k < 40; k++) write_cycle(32'h9E3779B9 * (k + 1) ^ (32'h1 << k % 32));
    write_cycle(32'h0); write_cycle(32'hFFFFFFFF);
    for (int b = 0; b < 16; b++)
      for (int w = 0; w < 4; w++)
        for (int f = 0; f < 16; f++)
          read_cycle(b[3:0], w[1:0], f[3:0], 32'h85EBCA6B * (b * 64 + w * 16 + f + 1));
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule